// File: doc/BRIEF.md
# Fully-Associative Victim Buffer

This block is a small fully-associative store placed beside a primary cache on its refill path. Every block the cache throws out is captured here, keyed by its full block address (tag plus set index), so the entries act as a handful of extra ways that any cache set may borrow. When the cache misses, it presents the missing block address to the buffer before asking the lower level. All entries are compared in parallel, giving a one-hot match vector. On a hit the stored block is handed back to the cache and the lower-level request is not needed. On a miss a miss pulse tells the cache to go ahead with the lower level.

A returned block leaves the buffer. If the cache evicts a block in the same cycle to make room for it, that block takes over the freed entry, so the two blocks trade places. A new block goes into the lowest-numbered empty entry. When every entry is full, a round-robin pointer selects the entry to overwrite.

Top module: `victim_buffer`

## Requirements
- R1: After synchronous reset every entry is empty, so any lookup misses.
- R2: An eviction (`evict_valid` high) with no lookup hit in the same cycle stores its address and data, and a later lookup of that address hits and returns that data.
- R3: Lookup results are registered. For a lookup presented in cycle N, exactly one of `rsp_hit` and `rsp_miss` is high in cycle N+1, and both are low in any cycle that follows a cycle without a lookup.
- R4: A lookup compares the full block address against all entries at once. At most one entry may match, and only an entry that holds a block can match. Addresses that differ only in their upper bits do not match.
- R5: A lookup hit with no eviction in the same cycle empties the matching entry, so a repeat lookup of the same address misses.
- R6: A lookup hit that comes with an eviction in the same cycle writes the evicted block into the entry just hit. After that the returned address misses and the evicted address hits.
- R7: A lookup miss raises `rsp_miss` and leaves the contents unchanged, so blocks held before the miss still hit afterwards.
- R8: An eviction with a new address goes into the lowest-numbered empty entry, and the round-robin pointer does not move.
- R9: An eviction with a new address into a full buffer overwrites the entry at the round-robin pointer. The pointer starts at entry 0 after reset and then advances by one, wrapping from the last entry to entry 0.
- R10: An eviction whose address is already held replaces that entry's data in place and takes no second entry.
- R11: `ret_addr` and `ret_data` carry the hit block in the cycle that `rsp_hit` is high, and are all zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | A block evicted from the primary cache is presented |
| evict_addr | input | ADDR_W | Block address (tag plus set index) of the evicted block |
| evict_data | input | DATA_W | Contents of the evicted block |
| lookup_valid | input | 1 | The primary cache missed and asks for a block |
| lookup_addr | input | ADDR_W | Block address being looked up |
| rsp_hit | output | 1 | The previous cycle's lookup found its block |
| rsp_miss | output | 1 | The previous cycle's lookup did not find its block, so the lower level may be asked |
| ret_addr | output | ADDR_W | Address of the block being returned to the cache |
| ret_data | output | DATA_W | Contents of the block being returned to the cache |

## Verification
Each lookup result (hit, miss, returned address and data) is due one clock after the lookup is presented. State changes from an eviction or a hit take effect at that same edge, so they can be seen from the next lookup onward. The bench drives one operation per cycle at the falling edge. It compares the outputs at the following falling edge with a model that is updated operation by operation from the requirements, so every result is checked in exactly the cycle it is due. Directed sequences cover reset, swap, in-place refresh, lowest-free placement and pointer wrap. A long pseudo-random sweep over sixteen addresses then mixes lookups and evictions, including addresses that differ only in their upper bit.

// File: rtl/vb_pkg.sv
package vb_pkg;

    // Upper bound on entries that the helper functions can scan.
    localparam int VB_MAX_ENTRIES = 32;

    // What the buffer does with its storage in one cycle.
    typedef enum logic [2:0] {
        ACT_NONE,       // nothing written or cleared
        ACT_TAKE,       // hit without eviction: matched entry is emptied
        ACT_SWAP,       // hit with eviction: evicted block replaces the hit one
        ACT_REFRESH,    // eviction of an address already held
        ACT_FILL_FREE,  // eviction into the lowest empty entry
        ACT_REPLACE     // eviction into a full buffer at the rotating pointer
    } vb_act_e;

    // Index of the set bit in a one-hot (or zero) vector.
    function automatic int unsigned vb_oh_index(input logic [VB_MAX_ENTRIES-1:0] oh);
        int unsigned idx;
        idx = 0;
        for (int i = 0; i < VB_MAX_ENTRIES; i++) begin
            if (oh[i]) idx = i;
        end
        return idx;
    endfunction

    // Lowest index below n whose bit is clear.
    function automatic int unsigned vb_first_zero(input logic [VB_MAX_ENTRIES-1:0] v,
                                                  input int unsigned n);
        int unsigned idx;
        idx = 0;
        for (int i = VB_MAX_ENTRIES - 1; i >= 0; i--) begin
            if (i < int'(n) && !v[i]) idx = i;
        end
        return idx;
    endfunction

    // Round-robin successor of v among n positions.
    function automatic int unsigned vb_wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26
) (
    input  logic [ADDR_W-1:0]  key,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ADDR_W-1:0]  addr_tab [ENTRIES],
    output logic [ENTRIES-1:0] match
);
    // One comparator per entry, all evaluated at once.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_vec[g] && (addr_tab[g] == key);
    end
endmodule

// File: rtl/vb_alloc.sv
module vb_alloc
    import vb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               replace_en,
    output logic               have_free,
    output logic [IDX_W-1:0]   free_idx,
    output logic [IDX_W-1:0]   rr_idx
);
    logic [IDX_W-1:0] rr_q;

    assign have_free = ~&valid_vec;
    assign free_idx  = IDX_W'(vb_first_zero(VB_MAX_ENTRIES'(valid_vec), ENTRIES));
    assign rr_idx    = rr_q;

    // The pointer moves only when a full buffer loses an entry to a new block.
    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (replace_en) begin
            rr_q <= IDX_W'(vb_wrap_inc(int'(rr_q), ENTRIES));
        end
    end
endmodule

// File: rtl/vb_store.sv
module vb_store #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ADDR_W-1:0]  addr_tab [ENTRIES],
    output logic [DATA_W-1:0]  data_tab [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic              v_q;
        logic [ADDR_W-1:0] a_q;
        logic [DATA_W-1:0] d_q;
        logic              wr_here;
        logic              clr_here;

        assign wr_here  = wr_en  && (wr_idx  == IDX_W'(g));
        assign clr_here = clr_en && (clr_idx == IDX_W'(g));

        // A write wins over a clear aimed at the same entry.
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                a_q <= '0;
                d_q <= '0;
            end else if (wr_here) begin
                v_q <= 1'b1;
                a_q <= wr_addr;
                d_q <= wr_data;
            end else if (clr_here) begin
                v_q <= 1'b0;
            end
        end

        assign valid_vec[g] = v_q;
        assign addr_tab[g]  = a_q;
        assign data_tab[g]  = d_q;
    end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [DATA_W-1:0] evict_data,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [DATA_W-1:0] ret_data
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_vec;
    logic [ADDR_W-1:0]  addr_tab [ENTRIES];
    logic [DATA_W-1:0]  data_tab [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] ev_match;
    logic               have_free;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   rr_idx;
    logic               lk_hit;
    logic               ev_dup;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   dup_idx;
    vb_act_e            act;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic               clr_en;
    logic               replace_en;

    // Parallel search for the requested block.
    vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_lk_match (
        .key       (lookup_addr),
        .valid_vec (valid_vec),
        .addr_tab  (addr_tab),
        .match     (lk_match)
    );

    // Parallel search for the evicted block, to keep addresses unique.
    vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_ev_match (
        .key       (evict_addr),
        .valid_vec (valid_vec),
        .addr_tab  (addr_tab),
        .match     (ev_match)
    );

    vb_alloc #(.ENTRIES(ENTRIES)) i_alloc (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .replace_en (replace_en),
        .have_free  (have_free),
        .free_idx   (free_idx),
        .rr_idx     (rr_idx)
    );

    vb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_addr   (evict_addr),
        .wr_data   (evict_data),
        .clr_en    (clr_en),
        .clr_idx   (hit_idx),
        .valid_vec (valid_vec),
        .addr_tab  (addr_tab),
        .data_tab  (data_tab)
    );

    always_comb begin
        lk_hit  = lookup_valid && (|lk_match);
        ev_dup  = evict_valid && (|ev_match);
        hit_idx = IDX_W'(vb_oh_index(VB_MAX_ENTRIES'(lk_match)));
        dup_idx = IDX_W'(vb_oh_index(VB_MAX_ENTRIES'(ev_match)));

        // Priority: swap/take on a hit, then refresh, then empty slot, then rotate.
        if (lk_hit && evict_valid)      act = ACT_SWAP;
        else if (lk_hit)                act = ACT_TAKE;
        else if (ev_dup)                act = ACT_REFRESH;
        else if (evict_valid && have_free) act = ACT_FILL_FREE;
        else if (evict_valid)           act = ACT_REPLACE;
        else                            act = ACT_NONE;
    end

    always_comb begin
        wr_en      = 1'b0;
        wr_idx     = '0;
        clr_en     = 1'b0;
        replace_en = 1'b0;
        unique case (act)
            ACT_TAKE: begin
                clr_en = 1'b1;
            end
            ACT_SWAP: begin
                wr_en  = 1'b1;
                wr_idx = hit_idx;
            end
            ACT_REFRESH: begin
                wr_en  = 1'b1;
                wr_idx = dup_idx;
            end
            ACT_FILL_FREE: begin
                wr_en  = 1'b1;
                wr_idx = free_idx;
            end
            ACT_REPLACE: begin
                wr_en      = 1'b1;
                wr_idx     = rr_idx;
                replace_en = 1'b1;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

    // Registered response; the returned block is read before the edge updates it.
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit  <= 1'b0;
            rsp_miss <= 1'b0;
            ret_addr <= '0;
            ret_data <= '0;
        end else begin
            rsp_hit  <= lk_hit;
            rsp_miss <= lookup_valid && !lk_hit;
            ret_addr <= lk_hit ? addr_tab[hit_idx] : '0;
            ret_data <= lk_hit ? data_tab[hit_idx] : '0;
        end
    end
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               lookup_valid,
    input logic               evict_valid,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] ev_match,
    input logic [ENTRIES-1:0] valid_vec,
    input logic               rsp_hit,
    input logic               rsp_miss
);
    assert_match_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    assert_evict_match_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev_match));

    assert_rsp_due_R3: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> (rsp_hit != rsp_miss));

    assert_rsp_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !lookup_valid |=> (!rsp_hit && !rsp_miss));

    assert_take_frees_R5: assert property (@(posedge clk) disable iff (rst)
        (lookup_valid && (|lk_match) && !evict_valid)
        |=> ($countones(valid_vec) + 1 == $past($countones(valid_vec))));

    assert_swap_keeps_count_R6: assert property (@(posedge clk) disable iff (rst)
        (lookup_valid && (|lk_match) && evict_valid)
        |=> ($countones(valid_vec) == $past($countones(valid_vec))));

    assert_miss_unchanged_R7: assert property (@(posedge clk) disable iff (rst)
        (lookup_valid && !(|lk_match) && !evict_valid) |=> $stable(valid_vec));

    assert_refresh_no_grow_R10: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && !lookup_valid && (|ev_match))
        |=> ($countones(valid_vec) == $past($countones(valid_vec))));
endmodule

bind victim_buffer vb_checker #(.ENTRIES(ENTRIES)) i_vb_checker (
    .clk          (clk),
    .rst          (rst),
    .lookup_valid (lookup_valid),
    .evict_valid  (evict_valid),
    .lk_match     (lk_match),
    .ev_match     (ev_match),
    .valid_vec    (valid_vec),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss)
);

// File: tb/test_victim_buffer.sv
`timescale 1ns/1ps
module test_victim_buffer;
    localparam int N  = 4;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          evict_valid = 1'b0;
    logic [AW-1:0] evict_addr = '0;
    logic [DW-1:0] evict_data = '0;
    logic          lookup_valid = 1'b0;
    logic [AW-1:0] lookup_addr = '0;
    logic          rsp_hit;
    logic          rsp_miss;
    logic [AW-1:0] ret_addr;
    logic [DW-1:0] ret_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state, kept from the requirements.
    bit            mv [N];
    logic [AW-1:0] ma [N];
    logic [DW-1:0] md [N];
    int            mptr;
    logic [31:0]   lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    victim_buffer #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) i_victim_buffer (
        .clk          (clk),
        .rst          (rst),
        .evict_valid  (evict_valid),
        .evict_addr   (evict_addr),
        .evict_data   (evict_data),
        .lookup_valid (lookup_valid),
        .lookup_addr  (lookup_addr),
        .rsp_hit      (rsp_hit),
        .rsp_miss     (rsp_miss),
        .ret_addr     (ret_addr),
        .ret_data     (ret_data)
    );

    function automatic int model_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return i;
        return -1;
    endfunction

    function automatic int model_free();
        for (int i = 0; i < N; i++) if (!mv[i]) return i;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        lookup_valid = 1'b0;
        evict_valid  = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin
            mv[i] = 1'b0;
            ma[i] = '0;
            md[i] = '0;
        end
        mptr = 0;
    endtask

    // One operation per cycle; called at a falling edge, returns at the next one.
    task automatic do_op(input bit lv, input logic [AW-1:0] la,
                         input bit ev, input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                         input string tag);
        int hi, di, fi;
        logic          e_hit, e_miss;
        logic [AW-1:0] e_addr;
        logic [DW-1:0] e_data;
        hi = lv ? model_find(la) : -1;
        di = ev ? model_find(ea) : -1;
        e_hit  = lv && (hi >= 0);
        e_miss = lv && (hi < 0);
        e_addr = e_hit ? ma[hi] : '0;
        e_data = e_hit ? md[hi] : '0;
        if (e_hit && ev) begin
            ma[hi] = ea; md[hi] = ed;
        end else if (e_hit) begin
            mv[hi] = 1'b0;
        end else if (ev && di >= 0) begin
            md[di] = ed;
        end else if (ev) begin
            fi = model_free();
            if (fi < 0) begin
                fi = mptr;
                mptr = (mptr + 1) % N;
            end
            mv[fi] = 1'b1; ma[fi] = ea; md[fi] = ed;
        end
        lookup_valid = lv; lookup_addr = la;
        evict_valid  = ev; evict_addr  = ea; evict_data = ed;
        @(posedge clk);
        @(negedge clk);
        lookup_valid = 1'b0;
        evict_valid  = 1'b0;
        n_cmp++;
        if ({rsp_hit, rsp_miss, ret_addr, ret_data} !== {e_hit, e_miss, e_addr, e_data}) begin
            n_bad++;
            $display("FAIL %s: hit/miss/addr/data actual=%b/%b/%h/%h expected=%b/%b/%h/%h",
                     tag, rsp_hit, rsp_miss, ret_addr, ret_data, e_hit, e_miss, e_addr, e_data);
        end
    endtask

    task automatic look(input logic [AW-1:0] a, input string tag);
        do_op(1'b1, a, 1'b0, '0, '0, tag);
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        do_op(1'b0, '0, 1'b1, a, d, tag);
    endtask

    function automatic logic [31:0] step_lfsr(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all): actual=running expected=finished");
        finish_run();
    end

    initial begin
        do_reset();

        // R1: empty after reset; R11: zero return on miss
        look(12'h010, "R1");
        look(12'h000, "R11");

        // R2 / R3 / R4: store then return, upper-bit alias must not match
        put(12'h021, 16'hA001, "R2");
        put(12'h022, 16'hA002, "R2");
        put(12'h023, 16'hA003, "R2");
        look(12'h822, "R4");
        look(12'h022, "R2");
        do_op(1'b0, '0, 1'b0, '0, '0, "R3");
        look(12'h022, "R5");

        // R6: swap on hit with simultaneous eviction
        do_op(1'b1, 12'h021, 1'b1, 12'h0B0, 16'hB0B0, "R6");
        look(12'h021, "R6");
        look(12'h0B0, "R6");

        // R7: a miss leaves contents intact
        look(12'h055, "R7");
        look(12'h023, "R7");

        // R8 / R9: lowest free slot, then rotating replacement with wrap
        do_reset();
        for (int i = 0; i < N; i++) put(AW'(12'h300 + i), DW'(16'hC000 + i), "R8");
        put(12'h304, 16'hC004, "R9");
        look(12'h300, "R9");
        look(12'h301, "R9");
        put(12'h305, 16'hC005, "R8");
        put(12'h306, 16'hC006, "R9");
        look(12'h305, "R9");
        put(12'h307, 16'hC007, "R9");
        put(12'h308, 16'hC008, "R9");
        put(12'h309, 16'hC009, "R9");
        for (int i = 4; i < 10; i++) look(AW'(12'h300 + i), "R9");

        // R10: refresh an address already held
        put(12'h3A0, 16'h1111, "R10");
        put(12'h3A0, 16'h2222, "R10");
        look(12'h3A0, "R10");
        look(12'h3A0, "R10");

        // Sweep: sixteen addresses, mixed lookups and evictions
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            bit lv, ev;
            logic [AW-1:0] la, ea;
            logic [DW-1:0] ed;
            lfsr = step_lfsr(lfsr); lfsr = step_lfsr(lfsr); lfsr = step_lfsr(lfsr);
            lv = lfsr[8] | lfsr[9];
            ev = lfsr[10];
            la = {lfsr[1], 8'h00, lfsr[4:2]};
            ea = {lfsr[11], 8'h00, lfsr[14:12]};
            ed = lfsr[31:16];
            if (lv && ev && model_find(la) >= 0) begin
                for (int t = 0; t < 16 && model_find(ea) >= 0; t++)
                    ea = {ea[AW-1] ^ ea[0], 8'h00, 3'(ea[2:0] + 3'd1)};
                if (model_find(ea) >= 0) ev = 1'b0;
            end
            do_op(lv, la, ev, ea, ed, "R4");
        end

        finish_run();
    end
endmodule